// File: doc/BRIEF.md
# Hop Parameter Store for Channel A

This block keeps sixteen sets of hop settings for channel A of a waveform synthesizer. Each set holds a 24-bit frequency word, a 12-bit amplitude word and a 12-bit phase word. External address lines pick one set, and the block presents channel A's effective frequency, amplitude and phase. For each of the three parameters, a separate enable decides whether the value comes from the selected set or from the channel's static setting. Turning an enable off does not touch the stored sets. Frequency alone can therefore hop between stored tones, as frequency-shift keying needs.

The host loads the store one field at a time by giving an entry index, a field code and a data word. A channel-cycle strobe marks the start of each sample. A small sequencer captures the hop address, the enables and the static settings on that strobe. It then reads the chosen entry and updates all three outputs together, so no parameter changes partway through a sample.

The sequencer has three states. S_WAIT idles until the strobe arrives; on the strobe it captures the inputs and moves to S_FETCH. S_FETCH registers the chosen entry's fields and always moves to S_UPDATE. S_UPDATE writes the output registers and always returns to S_WAIT. A strobe seen in S_FETCH or S_UPDATE has no effect.

Top module: `hop_param_store`

## Requirements
- R1: After reset, out_freq, out_amp and out_ph are zero, every stored field is zero, and the sequencer is in S_WAIT.
- R2: A write with wr_en high stores wr_data[23:0] into the frequency of entry wr_idx when wr_fld is 0. It stores wr_data[11:0] into the amplitude when wr_fld is 1, and wr_data[11:0] into the phase when wr_fld is 2. The other fields of that entry and all other entries keep their values.
- R3: A write with wr_fld equal to 3 changes no stored field.
- R4: A cyc_stb seen high at a clock edge while idle makes the outputs change at the second following edge, and not before.
- R5: hop_en bit 0 high gives out_freq from the captured entry's frequency; low gives the captured stat_freq.
- R6: hop_en bit 1 high gives out_amp from the captured entry's amplitude; low gives the captured stat_amp.
- R7: hop_en bit 2 high gives out_ph from the captured entry's phase; low gives the captured stat_ph.
- R8: Clearing a hop enable leaves the stored entry unchanged; setting the enable again brings back the stored value.
- R9: cyc_stb seen in S_FETCH or S_UPDATE starts no new capture, and the outputs reflect the address captured in S_WAIT.
- R10: hop_addr, hop_en and the static settings affect the outputs only through their values at the capturing strobe. Changes at other times leave the outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host field write strobe |
| wr_idx | input | 4 | Entry index for the write |
| wr_fld | input | 2 | Field code: 0 frequency, 1 amplitude, 2 phase, 3 none |
| wr_data | input | 24 | Write data, low bits used for 12-bit fields |
| hop_addr | input | 4 | External hop entry select |
| cyc_stb | input | 1 | Channel-cycle start strobe |
| hop_en | input | 3 | Hop enables: bit 0 frequency, bit 1 amplitude, bit 2 phase |
| stat_freq | input | 24 | Static frequency setting |
| stat_amp | input | 12 | Static amplitude setting |
| stat_ph | input | 12 | Static phase setting |
| out_freq | output | 24 | Effective channel A frequency |
| out_amp | output | 12 | Effective channel A amplitude |
| out_ph | output | 12 | Effective channel A phase |

## Verification
The hardest situation to reach is an input change that lands inside a capture window. This covers a new hop address, new enables or new static values arriving after the strobe but before the outputs update, and a strobe that stays high through S_FETCH and S_UPDATE. The stimulus holds cyc_stb high across three edges and switches hop_addr to a different, fully loaded entry right after the capture. In a separate case it changes enables and static settings in that same window. The outputs must then carry the values captured on the first edge.

// File: rtl/hop_pkg.sv
package hop_pkg;

    typedef enum logic [1:0] {
        FLD_FREQ = 2'd0,
        FLD_AMP  = 2'd1,
        FLD_PH   = 2'd2,
        FLD_NONE = 2'd3
    } hop_fld_e;

    typedef enum logic [1:0] {
        S_WAIT   = 2'd0,
        S_FETCH  = 2'd1,
        S_UPDATE = 2'd2
    } hop_state_e;

    localparam int unsigned EN_FREQ = 0;
    localparam int unsigned EN_AMP  = 1;
    localparam int unsigned EN_PH   = 2;
    localparam int unsigned N_PARAM = 3;

endpackage

// File: rtl/hop_seq.sv
module hop_seq
    import hop_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cyc_stb,
    output logic cap,
    output logic fetch,
    output logic upd
);

    hop_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_WAIT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        cap     = 1'b0;
        fetch   = 1'b0;
        upd     = 1'b0;
        unique case (state_q)
            S_WAIT: begin
                if (cyc_stb) begin
                    cap     = 1'b1;
                    state_d = S_FETCH;
                end
            end
            S_FETCH: begin
                fetch   = 1'b1;
                state_d = S_UPDATE;
            end
            S_UPDATE: begin
                upd     = 1'b1;
                state_d = S_WAIT;
            end
            default: state_d = S_WAIT;
        endcase
    end

    AST_STB_STARTS_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_WAIT && cyc_stb) |=> (state_q == S_FETCH)); // R4
    AST_FETCH_IGNORES_STB: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_FETCH) |=> (state_q == S_UPDATE)); // R9
    AST_UPDATE_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_UPDATE) |=> (state_q == S_WAIT)); // R9

endmodule

// File: rtl/hop_word_mem.sv
module hop_word_mem
    import hop_pkg::*;
#(
    parameter int unsigned DEPTH  = 16,
    parameter int unsigned FREQ_W = 24,
    parameter int unsigned AMP_W  = 12,
    parameter int unsigned PH_W   = 12,
    localparam int unsigned AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_idx,
    input  hop_fld_e          wr_fld,
    input  logic [FREQ_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [AW-1:0]     rd_addr,
    output logic [FREQ_W-1:0] rd_freq,
    output logic [AMP_W-1:0]  rd_amp,
    output logic [PH_W-1:0]   rd_ph
);

    logic [FREQ_W-1:0] freq_mem [DEPTH];
    logic [AMP_W-1:0]  amp_mem  [DEPTH];
    logic [PH_W-1:0]   ph_mem   [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < DEPTH; e++) begin
                freq_mem[e] <= '0;
                amp_mem[e]  <= '0;
                ph_mem[e]   <= '0;
            end
        end else if (wr_en) begin
            unique case (wr_fld)
                FLD_FREQ: freq_mem[wr_idx] <= wr_data;
                FLD_AMP:  amp_mem[wr_idx]  <= wr_data[AMP_W-1:0];
                FLD_PH:   ph_mem[wr_idx]   <= wr_data[PH_W-1:0];
                FLD_NONE: ;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_freq <= '0;
            rd_amp  <= '0;
            rd_ph   <= '0;
        end else if (rd_en) begin
            rd_freq <= freq_mem[rd_addr];
            rd_amp  <= amp_mem[rd_addr];
            rd_ph   <= ph_mem[rd_addr];
        end
    end

    AST_FREQ_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_fld == FLD_FREQ) |=> (freq_mem[$past(wr_idx)] == $past(wr_data))); // R2
    AST_READ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> ($stable(rd_freq) && $stable(rd_amp) && $stable(rd_ph))); // R10

endmodule

// File: rtl/hop_param_store.sv
module hop_param_store
    import hop_pkg::*;
#(
    parameter int unsigned DEPTH  = 16,
    parameter int unsigned FREQ_W = 24,
    parameter int unsigned AMP_W  = 12,
    parameter int unsigned PH_W   = 12,
    localparam int unsigned AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_idx,
    input  logic [1:0]        wr_fld,
    input  logic [FREQ_W-1:0] wr_data,
    input  logic [AW-1:0]     hop_addr,
    input  logic              cyc_stb,
    input  logic [N_PARAM-1:0] hop_en,
    input  logic [FREQ_W-1:0] stat_freq,
    input  logic [AMP_W-1:0]  stat_amp,
    input  logic [PH_W-1:0]   stat_ph,
    output logic [FREQ_W-1:0] out_freq,
    output logic [AMP_W-1:0]  out_amp,
    output logic [PH_W-1:0]   out_ph
);

    logic cap, fetch, upd;

    logic [AW-1:0]      addr_q;
    logic [N_PARAM-1:0] en_q;
    logic [FREQ_W-1:0]  sfreq_q;
    logic [AMP_W-1:0]   samp_q;
    logic [PH_W-1:0]    sph_q;

    logic [FREQ_W-1:0]  rd_freq;
    logic [AMP_W-1:0]   rd_amp;
    logic [PH_W-1:0]    rd_ph;

    hop_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .cyc_stb (cyc_stb),
        .cap     (cap),
        .fetch   (fetch),
        .upd     (upd)
    );

    hop_word_mem #(
        .DEPTH  (DEPTH),
        .FREQ_W (FREQ_W),
        .AMP_W  (AMP_W),
        .PH_W   (PH_W)
    ) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_fld  (hop_fld_e'(wr_fld)),
        .wr_data (wr_data),
        .rd_en   (fetch),
        .rd_addr (addr_q),
        .rd_freq (rd_freq),
        .rd_amp  (rd_amp),
        .rd_ph   (rd_ph)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            en_q    <= '0;
            sfreq_q <= '0;
            samp_q  <= '0;
            sph_q   <= '0;
        end else if (cap) begin
            addr_q  <= hop_addr;
            en_q    <= hop_en;
            sfreq_q <= stat_freq;
            samp_q  <= stat_amp;
            sph_q   <= stat_ph;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_freq <= '0;
            out_amp  <= '0;
            out_ph   <= '0;
        end else if (upd) begin
            out_freq <= en_q[EN_FREQ] ? rd_freq : sfreq_q;
            out_amp  <= en_q[EN_AMP]  ? rd_amp  : samp_q;
            out_ph   <= en_q[EN_PH]   ? rd_ph   : sph_q;
        end
    end

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> ($stable(out_freq) && $stable(out_amp) && $stable(out_ph))); // R4
    AST_CAPTURE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cap |=> ($stable(addr_q) && $stable(en_q))); // R10
    AST_STATIC_FREQ_PATH: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && !en_q[EN_FREQ]) |=> (out_freq == $past(sfreq_q))); // R5

endmodule

// File: tb/test_hop_param_store.sv
module test_hop_param_store;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_idx = '0;
    logic [1:0]  wr_fld = '0;
    logic [23:0] wr_data = '0;
    logic [3:0]  hop_addr = '0;
    logic        cyc_stb = 1'b0;
    logic [2:0]  hop_en = '0;
    logic [23:0] stat_freq = '0;
    logic [11:0] stat_amp = '0;
    logic [11:0] stat_ph = '0;
    logic [23:0] out_freq;
    logic [11:0] out_amp;
    logic [11:0] out_ph;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [23:0] mf [16];
    logic [11:0] ma [16];
    logic [11:0] mp [16];

    always #(CLK_PERIOD/2) clk = ~clk;

    hop_param_store i_hop_param_store (
        .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_idx (wr_idx),
        .wr_fld (wr_fld), .wr_data (wr_data), .hop_addr (hop_addr),
        .cyc_stb (cyc_stb), .hop_en (hop_en), .stat_freq (stat_freq),
        .stat_amp (stat_amp), .stat_ph (stat_ph), .out_freq (out_freq),
        .out_amp (out_amp), .out_ph (out_ph)
    );

    task automatic chk(input string req, input logic [23:0] got, input logic [23:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic chk3(input string req, input logic [23:0] f, input logic [11:0] a, input logic [11:0] p);
        chk({req, " freq"}, out_freq, f);
        chk({req, " amp"}, {12'd0, out_amp}, {12'd0, a});
        chk({req, " phase"}, {12'd0, out_ph}, {12'd0, p});
    endtask

    task automatic wr(input int idx, input int fld, input logic [23:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 4'(idx); wr_fld = 2'(fld); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (fld == 0) mf[idx] = d;
        else if (fld == 1) ma[idx] = d[11:0];
        else if (fld == 2) mp[idx] = d[11:0];
    endtask

    // strobe from idle; returns at the negedge after the output update edge
    task automatic sample(input int addr, input logic [2:0] en);
        @(negedge clk);
        hop_addr = 4'(addr); hop_en = en; cyc_stb = 1'b1;
        @(negedge clk);
        cyc_stb = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset;
        chk3("R1 reset outputs", 24'd0, 12'd0, 12'd0);
        sample(5, 3'b111);
        chk3("R1 reset memory", 24'd0, 12'd0, 12'd0);
    endtask

    task automatic t_fields;
        wr(3, 0, 24'hABCDE1); wr(3, 1, 24'hFFF5A5); wr(3, 2, 24'h000C3C);
        wr(9, 0, 24'h123456); wr(9, 1, 24'h0000F0); wr(9, 2, 24'h000777);
        wr(4, 0, 24'h00BEEF);
        sample(3, 3'b111);
        chk3("R2 entry3", 24'hABCDE1, 12'h5A5, 12'hC3C);
        sample(9, 3'b111);
        chk3("R2 entry9", 24'h123456, 12'h0F0, 12'h777);
        sample(4, 3'b111);
        chk3("R2 entry4 only freq", 24'h00BEEF, 12'h000, 12'h000);
    endtask

    task automatic t_field3;
        wr(9, 3, 24'hFFFFFF);
        sample(9, 3'b111);
        chk3("R3 field code 3", mf[9], ma[9], mp[9]);
    endtask

    task automatic t_timing;
        sample(3, 3'b111);
        @(negedge clk);
        hop_addr = 4'd9; cyc_stb = 1'b1;
        @(negedge clk);
        cyc_stb = 1'b0;
        chk("R4 one edge after strobe", out_freq, mf[3]);
        @(negedge clk);
        chk("R4 two edges after strobe old", out_freq, mf[3]);
        @(negedge clk);
        chk("R4 update edge", out_freq, mf[9]);
    endtask

    task automatic t_enables;
        stat_freq = 24'h111111; stat_amp = 12'h222; stat_ph = 12'h333;
        sample(3, 3'b001);
        chk3("R5 freq only hop", mf[3], 12'h222, 12'h333);
        sample(3, 3'b010);
        chk3("R6 amp only hop", 24'h111111, ma[3], 12'h333);
        sample(3, 3'b100);
        chk3("R7 phase only hop", 24'h111111, 12'h222, mp[3]);
        sample(9, 3'b000);
        chk3("R5 all static", 24'h111111, 12'h222, 12'h333);
    endtask

    task automatic t_keep;
        sample(9, 3'b000);
        sample(9, 3'b111);
        chk3("R8 re-enable restores", 24'h123456, 12'h0F0, 12'h777);
    endtask

    task automatic t_stb_held;
        sample(4, 3'b111);
        @(negedge clk);
        hop_addr = 4'd3; cyc_stb = 1'b1;
        @(negedge clk);
        hop_addr = 4'd9;
        @(negedge clk);
        @(negedge clk);
        cyc_stb = 1'b0;
        chk3("R9 strobe held", mf[3], ma[3], mp[3]);
        repeat (3) @(negedge clk);
        chk3("R9 no restart", mf[3], ma[3], mp[3]);
    endtask

    task automatic t_sample_only;
        stat_freq = 24'h111111; stat_amp = 12'h222; stat_ph = 12'h333;
        @(negedge clk);
        hop_addr = 4'd3; hop_en = 3'b111; cyc_stb = 1'b1;
        @(negedge clk);
        cyc_stb = 1'b0; hop_en = 3'b000; stat_freq = 24'h999999;
        @(negedge clk);
        @(negedge clk);
        chk3("R10 window change", mf[3], ma[3], mp[3]);
        hop_addr = 4'd9; stat_amp = 12'h444;
        repeat (4) @(negedge clk);
        chk3("R10 no strobe", mf[3], ma[3], mp[3]);
        sample(9, 3'b000);
        chk3("R10 next strobe", 24'h999999, 12'h444, 12'h333);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) begin mf[i] = '0; ma[i] = '0; mp[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_fields;
        t_field3;
        t_timing;
        t_enables;
        t_keep;
        t_stb_held;
        t_sample_only;
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule